// File: doc/BRIEF.md
# Hot-Plug Interrupt and System-Error Aggregator

This block collects the event status of a four-slot hot-plug bus controller and reduces it to one interrupt, one wakeup indication and one system-error level. Each slot has a latch-sensor change bit and a power-fault bit, each with its own system-error mask. Two controller-wide events sit beside them: a command-completion bit, set when the controller's busy flag falls, and an arbiter-timeout bit, set when a hot-plug bus request to the internal arbiter waits too long for a grant. Status is write-1-to-clear, and a hardware set in the same cycle as a clear wins.

Sources are masked twice. Per-source masks gate each event into an interrupt pending field or a system-error pending field, and global masks then gate those into the outputs. A read-only locator word shows which slots, or the arbiter, are behind a system error. The interrupt goes out either as a legacy pin level or as a message request, chosen by a routing enable and the function's interrupt-disable bit. While the system-error level is high and the system-error enable is set, a sticky received-system-error flag is set.

Software uses a word-wide register port with single-cycle writes and reads that return one cycle later. Register map (word address: content): 0 control, 1 event status, 2 slot status, 3 slot system-error masks, 4 locator, 5 interrupt pending. All outputs are registered.

Top module: `hp_event_agg`

## Requirements
- R1: After reset every output is 0, control reads 0x7F, slot system-error masks read 0xFF, and event status, slot status, locator and interrupt pending read 0.
- R2: Status bits clear when a 1 is written to their position at addresses 1 and 2. A hardware set in the same cycle as such a clear leaves the bit at 1.
- R3: The locator (address 4) is read-only. Bit 0 is arbiter-timeout status AND NOT control bit 3 (the arbiter system-error mask). Bit n+1 is set for slot n when its latch-change status (slot status bit n) is 1 and slot-mask bit n is 0, or when its power-fault status (slot status bit 4+n) is 1 and slot-mask bit 4+n is 0. All higher bits read 0.
- R4: Event status bit 1 sets on the TMO_CYC-th consecutive clock edge at which the bus request is high and the grant is low. A grant, or a dropped request, restarts the count.
- R5: Event status bit 0 sets on the clock edge after the busy input goes from 1 to 0.
- R6: One cycle after the state changes, the system-error output equals NOT control bit 1 (global system-error mask) AND (any locator bit 0 to 4 set).
- R7: Interrupt pending (address 5) is bit 0 = command complete AND NOT control bit 2, bit 1 = any latch change AND NOT control bit 4, bit 2 = any power fault AND NOT control bit 5, bit 3 = arbiter timeout AND NOT control bit 6. The wake output is 1 one cycle after this field becomes nonzero.
- R8: The interrupt level is wake AND NOT control bit 0 (global interrupt mask). It drives the pin output when the routing enable is 1 and interrupt-disable is 0, and drives the message-request output otherwise. The two outputs are never high together.
- R9: Event status bit 2 sets while the system-error output and the system-error enable are both 1.
- R10: Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid the cycle after rd_en, else 0 |
| slot_lc_set | input | NSLOT | Per-slot latch-sensor change events |
| slot_pf_set | input | NSLOT | Per-slot power-fault events |
| busy | input | 1 | Controller busy flag |
| arb_req | input | 1 | Hot-plug bus request to the internal arbiter |
| arb_gnt | input | 1 | Grant from the internal arbiter |
| route_pin_en | input | 1 | Select legacy pin delivery |
| int_disable | input | 1 | Function interrupt-disable bit |
| serr_en | input | 1 | System-error enable |
| irq_pin | output | 1 | Legacy interrupt pin level |
| irq_msg | output | 1 | Interrupt message request level |
| wake | output | 1 | Wakeup indication |
| serr_out | output | 1 | System-error level |

## Verification
The bench lands a busy fall in the same cycle as a write-1-to-clear of command complete; a design where the clear wins would read 0 there. It holds a request ungranted for one cycle fewer than the timeout after a grant-forced restart and reads the status on the boundary edge, so an off-by-one counter or one that does not restart would show the bit set one cycle early or late. It masks one slot's power fault while leaving its latch change visible and writes all ones to the locator, which would expose a merged mask or a writable locator. It also switches the interrupt-disable and global masks to catch pin and message delivery mixed up.

// File: rtl/hp_agg_pkg.sv
package hp_agg_pkg;
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_EVT   = 3'd1,
    REG_SLOT  = 3'd2,
    REG_SMASK = 3'd3,
    REG_LOC   = 3'd4,
    REG_IP    = 3'd5
  } reg_addr_e;

  localparam int CTRL_W    = 7;
  localparam int C_GIM     = 0;  // global interrupt mask
  localparam int C_GSM     = 1;  // global system-error mask
  localparam int C_CCIM    = 2;  // command-complete interrupt mask
  localparam int C_ASM     = 3;  // arbiter system-error mask
  localparam int C_LIM     = 4;  // latch-change interrupt mask
  localparam int C_PIM     = 5;  // power-fault interrupt mask
  localparam int C_AIM     = 6;  // arbiter-timeout interrupt mask
  localparam logic [CTRL_W-1:0] CTRL_RST = 7'h7F;

  localparam int EVT_W     = 3;
  localparam int E_CC      = 0;
  localparam int E_AT      = 1;
  localparam int E_RSE     = 2;

  localparam int IP_W      = 4;
endpackage

// File: rtl/hp_w1c_bank.sv
module hp_w1c_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  // set has priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/hp_grant_timer.sv
module hp_grant_timer #(
  parameter int TMO_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic gnt,
  output logic hit
);
  localparam int CW = $clog2(TMO_CYC + 1);

  logic [CW-1:0] cnt;
  logic          waiting;

  assign waiting = req & ~gnt;
  assign hit     = waiting && (cnt == CW'(TMO_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !waiting)            cnt <= '0;
    else if (cnt != CW'(TMO_CYC))   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hp_out_stage.sv
module hp_out_stage #(
  parameter int IPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IPW-1:0] ip_vec,
  input  logic           gim,
  input  logic           gsm,
  input  logic           serr_src,
  input  logic           route_pin_en,
  input  logic           int_disable,
  output logic           wake,
  output logic           irq_pin,
  output logic           irq_msg,
  output logic           serr_out
);
  logic wake_d, irq_lvl, use_pin;

  assign wake_d  = |ip_vec;
  assign irq_lvl = wake_d & ~gim;
  assign use_pin = route_pin_en & ~int_disable;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake     <= 1'b0;
      irq_pin  <= 1'b0;
      irq_msg  <= 1'b0;
      serr_out <= 1'b0;
    end else begin
      wake     <= wake_d;
      irq_pin  <= irq_lvl & use_pin;
      irq_msg  <= irq_lvl & ~use_pin;
      serr_out <= serr_src & ~gsm;
    end
  end
endmodule

// File: rtl/hp_event_agg.sv
module hp_event_agg
  import hp_agg_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int TMO_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NSLOT-1:0] slot_lc_set,
  input  logic [NSLOT-1:0] slot_pf_set,
  input  logic             busy,
  input  logic             arb_req,
  input  logic             arb_gnt,
  input  logic             route_pin_en,
  input  logic             int_disable,
  input  logic             serr_en,
  output logic             irq_pin,
  output logic             irq_msg,
  output logic             wake,
  output logic             serr_out
);
  localparam int SW   = 2 * NSLOT;
  localparam int WUSE = (SW > CTRL_W) ? SW : CTRL_W;
  localparam int LOCW = NSLOT + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [SW-1:0]     smask_q;
  logic [SW-1:0]     slot_sts;
  logic [EVT_W-1:0]  evt_sts;
  logic [EVT_W-1:0]  evt_set, evt_clr;
  logic [SW-1:0]     slot_clr;
  logic              busy_q;
  logic              tmo_hit;
  logic              cc_sts, at_sts;
  logic [NSLOT-1:0]  slot_pend;
  logic              arb_pend;
  logic [LOCW-1:0]   locator;
  logic [IP_W-1:0]   ip_vec;
  logic              serr_src;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DW-1:WUSE];

  wire wr_ctrl  = wr_en && (addr == AW'(REG_CTRL));
  wire wr_evt   = wr_en && (addr == AW'(REG_EVT));
  wire wr_slot  = wr_en && (addr == AW'(REG_SLOT));
  wire wr_smask = wr_en && (addr == AW'(REG_SMASK));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RST;
      smask_q <= '1;
      busy_q  <= 1'b0;
    end else begin
      busy_q <= busy;
      if (wr_ctrl)  ctrl_q  <= wdata[CTRL_W-1:0];
      if (wr_smask) smask_q <= wdata[SW-1:0];
    end
  end

  hp_grant_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk(clk), .rst(rst), .req(arb_req), .gnt(arb_gnt), .hit(tmo_hit)
  );

  assign evt_set[E_CC]  = busy_q & ~busy;
  assign evt_set[E_AT]  = tmo_hit;
  assign evt_set[E_RSE] = serr_out & serr_en;
  assign evt_clr        = wr_evt ? wdata[EVT_W-1:0] : '0;
  assign slot_clr       = wr_slot ? wdata[SW-1:0] : '0;

  hp_w1c_bank #(.W(EVT_W)) u_evt (
    .clk(clk), .rst(rst), .set(evt_set), .clr(evt_clr), .q(evt_sts)
  );

  hp_w1c_bank #(.W(SW)) u_slot (
    .clk(clk), .rst(rst), .set({slot_pf_set, slot_lc_set}), .clr(slot_clr), .q(slot_sts)
  );

  assign cc_sts = evt_sts[E_CC];
  assign at_sts = evt_sts[E_AT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign slot_pend[i] = (slot_sts[i]         & ~smask_q[i])
                        | (slot_sts[NSLOT + i] & ~smask_q[NSLOT + i]);
  end

  assign arb_pend = at_sts & ~ctrl_q[C_ASM];
  assign locator  = {slot_pend, arb_pend};
  assign serr_src = |locator;

  assign ip_vec[0] = cc_sts & ~ctrl_q[C_CCIM];
  assign ip_vec[1] = (|slot_sts[NSLOT-1:0])  & ~ctrl_q[C_LIM];
  assign ip_vec[2] = (|slot_sts[SW-1:NSLOT]) & ~ctrl_q[C_PIM];
  assign ip_vec[3] = at_sts & ~ctrl_q[C_AIM];

  hp_out_stage #(.IPW(IP_W)) u_out (
    .clk(clk), .rst(rst), .ip_vec(ip_vec),
    .gim(ctrl_q[C_GIM]), .gsm(ctrl_q[C_GSM]), .serr_src(serr_src),
    .route_pin_en(route_pin_en), .int_disable(int_disable),
    .wake(wake), .irq_pin(irq_pin), .irq_msg(irq_msg), .serr_out(serr_out)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      AW'(REG_CTRL):  rd_mux = DW'(ctrl_q);
      AW'(REG_EVT):   rd_mux = DW'(evt_sts);
      AW'(REG_SLOT):  rd_mux = DW'(slot_sts);
      AW'(REG_SMASK): rd_mux = DW'(smask_q);
      AW'(REG_LOC):   rd_mux = DW'(locator);
      AW'(REG_IP):    rd_mux = DW'(ip_vec);
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end
endmodule

// File: rtl/hp_event_agg_chk.sv
module hp_event_agg_chk #(
  parameter int IPW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           arb_req,
  input logic           arb_gnt,
  input logic           irq_pin,
  input logic           irq_msg,
  input logic           wake,
  input logic           cc_sts,
  input logic           at_sts,
  input logic [IPW-1:0] ip_vec
);
  assert_pin_msg_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(irq_pin && irq_msg));

  assert_irq_needs_wake_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_pin || irq_msg) |-> wake);

  assert_cc_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |=> cc_sts);

  assert_tmo_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(at_sts) |-> $past(arb_req && !arb_gnt));

  assert_wake_tracks_ip_R7: assert property (@(posedge clk) disable iff (rst)
    wake == $past(|ip_vec));
endmodule

bind hp_event_agg hp_event_agg_chk #(.IPW(hp_agg_pkg::IP_W)) u_chk (.*);

// File: tb/sim_hp_event_agg.sv
`timescale 1ns/1ps
module sim_hp_event_agg;
  localparam int NSLOT = 4, DW = 32, AW = 3, TMO = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NSLOT-1:0] slot_lc_set = '0, slot_pf_set = '0;
  logic busy = 0, arb_req = 0, arb_gnt = 0;
  logic route_pin_en = 1, int_disable = 0, serr_en = 0;
  logic irq_pin, irq_msg, wake, serr_out;

  always #4 clk = ~clk;  // 125 MHz

  hp_event_agg #(.NSLOT(NSLOT), .DW(DW), .AW(AW), .TMO_CYC(TMO)) u0 (.*);

  typedef struct {
    int          due;
    bit          is_rd;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int cyc = 0, ntest = 0, nfail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expectations whose cycle has come
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = it.is_rd ? rdata : {28'd0, irq_pin, irq_msg, wake, serr_out};
      ntest++;
      if (act !== it.exp) begin
        nfail++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    rd_en = 1; addr = a;
    it.due = cyc + 1; it.is_rd = 1; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    tick();
    rd_en = 0;
  endtask

  // expected {irq_pin, irq_msg, wake, serr_out}
  task automatic chk_out(input logic [3:0] e, input string tag);
    item_t it;
    it.due = cyc; it.is_rd = 0; it.exp = {28'd0, e}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 0;
    tick();
    // R1 reset state
    chk_out(4'b0000, "R1 outputs");
    rd(3'd0, 32'h7F, "R1 ctrl");
    rd(3'd3, 32'hFF, "R1 smask");
    rd(3'd1, 32'h0,  "R1 evt");
    rd(3'd2, 32'h0,  "R1 slot");
    rd(3'd4, 32'h0,  "R1 loc");
    rd(3'd5, 32'h0,  "R1 ip");

    // R5 command complete on busy fall, R7/R8 pin delivery
    wr(3'd0, 32'h0);
    busy = 1; tick(2);
    busy = 0; tick(2);
    chk_out(4'b1010, "R8 pin route");
    rd(3'd1, 32'h1, "R5 cc status");
    rd(3'd5, 32'h1, "R7 ip cc");
    int_disable = 1; tick();
    chk_out(4'b0110, "R8 msg route");
    int_disable = 0;
    wr(3'd0, 32'h1); tick();
    chk_out(4'b0010, "R8 global int mask");
    wr(3'd0, 32'h0);

    // R2 write-1-to-clear and set-wins
    wr(3'd1, 32'h1); tick();
    chk_out(4'b0000, "R2 clear drops wake");
    rd(3'd1, 32'h0, "R2 cleared");
    busy = 1; tick();
    busy = 0; wr(3'd1, 32'h1);
    rd(3'd1, 32'h1, "R2 set wins");
    wr(3'd1, 32'h1);
    rd(3'd1, 32'h0, "R2 cleared again");

    // R3/R6 slot system-error path
    slot_lc_set = 4'b0100; tick(); slot_lc_set = '0;
    rd(3'd2, 32'h04, "R3 slot status");
    rd(3'd4, 32'h0,  "R3 masked by reset masks");
    wr(3'd3, 32'h00); tick();
    chk_out(4'b1011, "R6 serr from slot2");
    rd(3'd4, 32'h08, "R3 slot2 locator");
    wr(3'd3, 32'h20);
    slot_pf_set = 4'b0010; tick(); slot_pf_set = '0;
    rd(3'd2, 32'h24, "R3 slot status pf");
    rd(3'd4, 32'h08, "R3 pf slot1 masked");
    wr(3'd3, 32'h00);
    rd(3'd4, 32'h0C, "R3 pf slot1 unmasked");
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, 32'h0C, "R3 locator read-only");

    // R9 received system error
    serr_en = 1; tick(2); serr_en = 0;
    rd(3'd1, 32'h4, "R9 rse flag");
    wr(3'd1, 32'h4);
    rd(3'd1, 32'h0, "R9 rse cleared");

    // R6 global system-error mask
    wr(3'd0, 32'h2); tick();
    chk_out(4'b1010, "R6 global serr mask");
    wr(3'd2, 32'hFF);
    wr(3'd0, 32'h0); tick(2);
    chk_out(4'b0000, "R2 slot cleared");

    // R4 grant timeout with restart
    arb_req = 1; tick(10);
    arb_gnt = 1; tick();
    arb_gnt = 0; tick(TMO - 1);
    rd(3'd1, 32'h0, "R4 not yet at boundary");
    rd(3'd1, 32'h2, "R4 timeout set");
    arb_req = 0;
    rd(3'd4, 32'h1, "R3 arbiter locator bit");
    chk_out(4'b1011, "R6 serr from arbiter");
    wr(3'd0, 32'h08);
    rd(3'd4, 32'h0, "R3 arbiter serr mask");
    rd(3'd5, 32'h8, "R7 ip arbiter");

    // R10 unmapped
    rd(3'd6, 32'h0, "R10 addr6");
    rd(3'd7, 32'h0, "R10 addr7");

    tick(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule